// File: doc/BRIEF.md
# Four-Phase Bundled-Data Stage Controller

This block sequences one stage of a bundled-data pipeline. It sits between an upstream request/acknowledge pair and a downstream one, and it starts a separate datapath and waits for the datapath to report completion. Every wire uses return-to-zero (four-phase) signalling. A transfer is one fixed ring of twelve level changes. The changes alternate between an input the controller waits for and an output the controller drives. In the rising half, each output goes high after its trigger input: `start` after `reqIn`, `reqOut` after `done`, and `ackIn` after `ackOut`. The falling half repeats the same order with low levels. The upstream data is bundled with `reqIn` and must stay stable until `ackIn` rises. After that the upstream may change it.

The controller is a clocked state machine that watches input levels. A parameterised chain of sampling registers can sit in front of the state machine when the handshake wires come from another timing domain. If any input moves when the ring does not allow it, a sticky `protocolError` output is raised and the controller freezes until reset. A counter of completed transfers is provided so that tests can see progress.

Top module: `hs_stage_ctrl`

## Requirements
- R1: While `rstN` is low, and on the first cycle after it is released, `start`, `reqOut`, `ackIn` and `protocolError` are 0 and `transferCount` is 0.
- R2: An input level applied between clock edges reaches the state machine after `SYNC_STAGES` sampling registers. The output that reacts to it changes on the (`SYNC_STAGES`+1)-th rising edge after the change, counting the first edge that sees the new level as edge 1.
- R3: Rising half: `start` rises only after `reqIn` is seen high, `reqOut` rises only after `done` is seen high, and `ackIn` rises only after `ackOut` is seen high, in that order.
- R4: Falling half: `start` falls after `reqIn` is seen low, `reqOut` falls after `done` is seen low, and `ackIn` falls after `ackOut` is seen low, in that order. The controller then waits again for `reqIn` high.
- R5: Each complete twelve-event ring adds one to `transferCount`, on the same edge at which `ackIn` falls. The count wraps modulo 2^`COUNT_W`.
- R6: While the awaited input holds its old level and the other inputs hold their required levels, no output changes, however long the wait lasts.
- R7: If an input other than the awaited one differs from its required level, `protocolError` goes to 1 on the edge at which that level is sampled by the state machine. This also covers two inputs moving together. The flag stays at 1 until reset.
- R8: While `protocolError` is 1, `start`, `reqOut`, `ackIn` and `transferCount` keep their values whatever the inputs do. A reset clears everything back to the R1 state.
- R9: At most one of `start`, `reqOut` and `ackIn` changes on any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | 1 | Upstream request, data valid while high |
| ackOut | input | 1 | Downstream acknowledge |
| done | input | 1 | Datapath completion |
| ackIn | output | 1 | Acknowledge to upstream |
| reqOut | output | 1 | Request to downstream |
| start | output | 1 | Datapath start |
| protocolError | output | 1 | Sticky out-of-order input flag |
| transferCount | output | COUNT_W | Completed transfers, wrapping |

## Verification
The bench builds the controller with `SYNC_STAGES` = 2 and `COUNT_W` = 4. The two-register sampler makes the reaction latency longer than one cycle, so an error of one cycle in the latency shows up as a mismatch. The 4-bit counter wraps after sixteen transfers, and the bench runs eighteen rings, so the wrap is reached in a short run. The bench drives the environment side of the handshake with varying datapath delays. It also injects out-of-order edges: an early `done`, an early `ackOut` drop, and two inputs changing together. This exercises the sticky freeze and the recovery through reset.

// File: rtl/hs_stage_pkg.sv
package hs_stage_pkg;

  // Waiting positions of the twelve-event ring; each names the awaited input level.
  typedef enum logic [2:0] {
    P_REQ_HI  = 3'd0,
    P_DONE_HI = 3'd1,
    P_ACK_HI  = 3'd2,
    P_REQ_LO  = 3'd3,
    P_DONE_LO = 3'd4,
    P_ACK_LO  = 3'd5
  } ringPos_e;

  // Input levels as seen by the control after sampling.
  typedef struct packed {
    logic reqIn;
    logic done;
    logic ackOut;
  } chanLevels_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic countInc;
  } ctlStrobes_t;

endpackage

// File: rtl/hs_stage_dp.sv
module hs_stage_dp
  import hs_stage_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int COUNT_W     = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqInRaw,
  input  logic               doneRaw,
  input  logic               ackOutRaw,
  input  ctlStrobes_t        strobe,
  output chanLevels_t        seen,
  output logic [COUNT_W-1:0] count
);

  localparam int LEVEL_W = $bits(chanLevels_t);

  logic [LEVEL_W-1:0] rawVec;
  assign rawVec = {reqInRaw, doneRaw, ackOutRaw};

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign seen = chanLevels_t'(rawVec);
    end else begin : g_sampler
      logic [LEVEL_W-1:0] stageQ [SYNC_STAGES];
      always_ff @(posedge clk) begin
        if (!rstN) begin
          for (int i = 0; i < SYNC_STAGES; i++) stageQ[i] <= '0;
        end else begin
          stageQ[0] <= rawVec;
          for (int i = 1; i < SYNC_STAGES; i++) stageQ[i] <= stageQ[i-1];
        end
      end
      assign seen = chanLevels_t'(stageQ[SYNC_STAGES-1]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)                count <= '0;
    else if (strobe.countInc) count <= count + COUNT_W'(1);
  end

  // R5: each strobe advances the counter by exactly one, wrapping.
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rstN)
    strobe.countInc |=> count == $past(count) + COUNT_W'(1));
  // R8: without a strobe the counter holds.
  a_r8_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.countInc |=> $stable(count));

endmodule

// File: rtl/hs_stage_fsm.sv
module hs_stage_fsm
  import hs_stage_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  chanLevels_t seen,
  output ctlStrobes_t strobe,
  output logic        start,
  output logic        reqOut,
  output logic        ackIn,
  output logic        protocolError
);

  ringPos_e pos, posNext;
  logic     levelsOk;
  logic     fire;

  // levelsOk: the two non-awaited inputs sit at their required levels.
  // fire: the awaited input has reached its new level.
  always_comb begin
    levelsOk = 1'b0;
    fire     = 1'b0;
    posNext  = pos;
    unique case (pos)
      P_REQ_HI:  begin levelsOk = !seen.done  && !seen.ackOut; fire =  seen.reqIn;  posNext = P_DONE_HI; end
      P_DONE_HI: begin levelsOk =  seen.reqIn && !seen.ackOut; fire =  seen.done;   posNext = P_ACK_HI;  end
      P_ACK_HI:  begin levelsOk =  seen.reqIn &&  seen.done;   fire =  seen.ackOut; posNext = P_REQ_LO;  end
      P_REQ_LO:  begin levelsOk =  seen.done  &&  seen.ackOut; fire = !seen.reqIn;  posNext = P_DONE_LO; end
      P_DONE_LO: begin levelsOk = !seen.reqIn &&  seen.ackOut; fire = !seen.done;   posNext = P_ACK_LO;  end
      P_ACK_LO:  begin levelsOk = !seen.reqIn && !seen.done;   fire = !seen.ackOut; posNext = P_REQ_HI;  end
      default:   begin levelsOk = 1'b0;                        fire = 1'b0;         posNext = P_REQ_HI;  end
    endcase
  end

  logic advance;
  assign advance         = !protocolError && levelsOk && fire;
  assign strobe.countInc = advance && (pos == P_ACK_LO);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos           <= P_REQ_HI;
      start         <= 1'b0;
      reqOut        <= 1'b0;
      ackIn         <= 1'b0;
      protocolError <= 1'b0;
    end else if (!protocolError) begin
      if (!levelsOk) begin
        protocolError <= 1'b1;
      end else if (fire) begin
        pos <= posNext;
        unique case (pos)
          P_REQ_HI:  start  <= 1'b1;
          P_DONE_HI: reqOut <= 1'b1;
          P_ACK_HI:  ackIn  <= 1'b1;
          P_REQ_LO:  start  <= 1'b0;
          P_DONE_LO: reqOut <= 1'b0;
          P_ACK_LO:  ackIn  <= 1'b0;
          default:   pos    <= P_REQ_HI;
        endcase
      end
    end
  end

  // R3: rising outputs follow their own trigger, seen high.
  a_r3_start_after_req: assert property (@(posedge clk) disable iff (!rstN)
    $rose(start) |-> $past(seen.reqIn) && !$past(seen.done) && !$past(seen.ackOut));
  a_r3_reqout_after_done: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqOut) |-> $past(seen.done) && $past(start));
  a_r3_ackin_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackIn) |-> $past(seen.ackOut) && $past(reqOut));
  // R4: falling outputs follow their trigger, seen low.
  a_r4_start_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(start) |-> !$past(seen.reqIn) && $past(ackIn));
  a_r4_ackin_fall: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackIn) |-> !$past(seen.ackOut) && !$past(reqOut) && !$past(start));
  // R9: one output change per edge.
  a_r9_single_change: assert property (@(posedge clk) disable iff (!rstN)
    $countones({start, reqOut, ackIn} ^ $past({start, reqOut, ackIn})) <= 1);
  // R7: error is sticky.
  a_r7_error_sticky: assert property (@(posedge clk) disable iff (!rstN)
    protocolError |=> protocolError);
  // R8: outputs frozen while in error.
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rstN)
    protocolError |=> $stable({start, reqOut, ackIn}) && !strobe.countInc);

endmodule

// File: rtl/hs_stage_ctrl.sv
module hs_stage_ctrl
  import hs_stage_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int COUNT_W     = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqIn,
  input  logic               ackOut,
  input  logic               done,
  output logic               ackIn,
  output logic               reqOut,
  output logic               start,
  output logic               protocolError,
  output logic [COUNT_W-1:0] transferCount
);

  chanLevels_t seenLevels;
  ctlStrobes_t ctlStrobe;

  hs_stage_dp #(
    .SYNC_STAGES(SYNC_STAGES),
    .COUNT_W    (COUNT_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .reqInRaw (reqIn),
    .doneRaw  (done),
    .ackOutRaw(ackOut),
    .strobe   (ctlStrobe),
    .seen     (seenLevels),
    .count    (transferCount)
  );

  hs_stage_fsm u_fsm (
    .clk          (clk),
    .rstN         (rstN),
    .seen         (seenLevels),
    .strobe       (ctlStrobe),
    .start        (start),
    .reqOut       (reqOut),
    .ackIn        (ackIn),
    .protocolError(protocolError)
  );

  // R5: counter moves only when ackIn falls.
  a_r5_count_with_ackin: assert property (@(posedge clk) disable iff (!rstN)
    (transferCount != $past(transferCount)) |-> $fell(ackIn));

endmodule

// File: tb/hs_stage_ctrl_tb.sv
module hs_stage_ctrl_tb;

  localparam int SYNC_STAGES = 2;
  localparam int COUNT_W     = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqIn = 1'b0, ackOut = 1'b0, done = 1'b0;
  logic ackIn, reqOut, start, protocolError;
  logic [COUNT_W-1:0] transferCount;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string curReq = "R1";

  always #5 clk = ~clk;

  hs_stage_ctrl #(.SYNC_STAGES(SYNC_STAGES), .COUNT_W(COUNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .ackOut(ackOut), .done(done),
    .ackIn(ackIn), .reqOut(reqOut), .start(start),
    .protocolError(protocolError), .transferCount(transferCount)
  );

  // Behavioural reference: delay line of input vectors, a ring index, last accepted levels.
  bit [2:0] delayQ[$];
  int       mPhase;
  bit [2:0] mLast;      // {reqIn, done, ackOut} after the last accepted event
  bit [2:0] mOuts;      // {start, reqOut, ackIn}
  bit       mErr;
  int       mCount;

  task automatic modelReset();
    delayQ.delete();
    for (int i = 0; i < SYNC_STAGES; i++) delayQ.push_back(3'b000);
    mPhase = 0; mLast = 3'b000; mOuts = 3'b000; mErr = 0; mCount = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      modelReset();
    end else begin
      bit [2:0] cur;
      int idx;
      bit [2:0] others;
      delayQ.push_back({reqIn, done, ackOut});
      cur = delayQ.pop_front();
      if (!mErr) begin
        idx = 2 - (mPhase % 3);            // bit of the awaited input
        others = (cur ^ mLast) & ~(3'b001 << idx);
        if (others != 0) begin
          mErr = 1;
        end else if (cur[idx] != mLast[idx]) begin
          mLast[idx] = cur[idx];
          mOuts[idx] = (mPhase < 3);
          if (mPhase == 5) mCount = (mCount + 1) % (1 << COUNT_W);
          mPhase = (mPhase + 1) % 6;
        end
      end
    end
  end

  task automatic check(string req, string what, int actual, int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, actual, expected, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (rstN && cycles > 0) begin
      check(curReq, "outs{start,reqOut,ackIn}", {start, reqOut, ackIn}, mOuts);
      check(curReq, "protocolError", protocolError, mErr);
      check(curReq, "transferCount", transferCount, mCount);
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  function automatic logic outSig(int which);
    case (which)
      0: return start;
      1: return reqOut;
      default: return ackIn;
    endcase
  endfunction

  task automatic waitOut(int which, logic val);
    for (int i = 0; i < 60; i++) begin
      if (outSig(which) == val) return;
      @(negedge clk);
    end
    check(curReq, "handshake wait timeout", outSig(which), val);
  endtask

  // Environment side of one correct ring; gap sets the datapath delay.
  task automatic doTransfer(int gap);
    reqIn = 1'b1;  waitOut(0, 1'b1);
    repeat (gap) @(negedge clk);
    done = 1'b1;   waitOut(1, 1'b1);
    ackOut = 1'b1; waitOut(2, 1'b1);
    reqIn = 1'b0;  waitOut(0, 1'b0);
    repeat (gap) @(negedge clk);
    done = 1'b0;   waitOut(1, 1'b0);
    ackOut = 1'b0; waitOut(2, 1'b0);
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0; reqIn = 1'b0; done = 1'b0; ackOut = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "start in reset", start, 0);
    check("R1", "protocolError in reset", protocolError, 0);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    modelReset();
    // R1: reset state
    curReq = "R1";
    repeat (3) @(negedge clk);
    check("R1", "outs in reset", {start, reqOut, ackIn}, 0);
    check("R1", "count in reset", transferCount, 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "outs after release", {start, reqOut, ackIn, protocolError}, 0);

    // R2: latency of SYNC_STAGES+1 edges
    curReq = "R2";
    reqIn = 1'b1;
    repeat (SYNC_STAGES) @(negedge clk);
    check("R2", "start before latency", start, 0);
    @(negedge clk);
    check("R2", "start at latency", start, 1);

    // R3 / R4: finish this ring manually
    curReq = "R3";
    done = 1'b1; waitOut(1, 1'b1);
    check("R3", "reqOut high after done", reqOut, 1);
    ackOut = 1'b1; waitOut(2, 1'b1);
    check("R3", "ackIn high after ackOut", ackIn, 1);
    curReq = "R4";
    reqIn = 1'b0; waitOut(0, 1'b0);
    check("R4", "start low after reqIn low", start, 0);
    done = 1'b0; waitOut(1, 1'b0);
    ackOut = 1'b0; waitOut(2, 1'b0);
    check("R4", "ackIn low after ackOut low", ackIn, 0);
    check("R5", "count after first ring", transferCount, 1);

    // R6: long wait with awaited input unchanged
    curReq = "R6";
    repeat (25) @(negedge clk);
    check("R6", "idle outs", {start, reqOut, ackIn}, 0);
    reqIn = 1'b1; waitOut(0, 1'b1);
    repeat (20) @(negedge clk);
    check("R6", "waiting for done", {start, reqOut, ackIn}, 3'b100);
    done = 1'b1; waitOut(1, 1'b1);
    ackOut = 1'b1; waitOut(2, 1'b1);
    reqIn = 1'b0; waitOut(0, 1'b0);
    done = 1'b0; waitOut(1, 1'b0);
    ackOut = 1'b0; waitOut(2, 1'b0);
    check("R6", "count after waited ring", transferCount, 2);

    // R5: wrap after sixteen more rings with varying gaps
    curReq = "R5";
    for (int k = 0; k < 16; k++) doTransfer(k % 4);
    repeat (3) @(negedge clk);
    check("R5", "count wrapped", transferCount, 2);

    // R7 / R8: done rises while waiting for reqIn
    curReq = "R7";
    done = 1'b1;
    repeat (SYNC_STAGES + 1) @(negedge clk);
    check("R7", "error on early done", protocolError, 1);
    curReq = "R8";
    reqIn = 1'b1; ackOut = 1'b1;
    repeat (10) @(negedge clk);
    check("R8", "outs frozen", {start, reqOut, ackIn}, 0);
    check("R8", "count frozen", transferCount, 2);
    check("R7", "error sticky", protocolError, 1);
    curReq = "R1";
    applyReset();
    check("R8", "reset clears error", protocolError, 0);
    check("R8", "reset clears count", transferCount, 0);

    // R7: ackOut drops early while waiting for reqIn low
    curReq = "R7";
    reqIn = 1'b1; waitOut(0, 1'b1);
    done = 1'b1; waitOut(1, 1'b1);
    ackOut = 1'b1; waitOut(2, 1'b1);
    ackOut = 1'b0;
    repeat (SYNC_STAGES + 1) @(negedge clk);
    check("R7", "error on early ackOut drop", protocolError, 1);
    check("R8", "ackIn frozen high", ackIn, 1);
    curReq = "R1";
    applyReset();

    // R7 / R9: two inputs rise together
    curReq = "R7";
    reqIn = 1'b1; done = 1'b1;
    repeat (SYNC_STAGES + 1) @(negedge clk);
    check("R7", "error on simultaneous edges", protocolError, 1);
    check("R9", "no output moved", {start, reqOut, ackIn}, 0);
    curReq = "R1";
    applyReset();
    curReq = "R9";
    doTransfer(1);
    check("R9", "ring after recovery", transferCount, 1);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule